// File: doc/BRIEF.md
# Multiplexed BCD digit scanner

This block presents a five-digit conversion result on a time-multiplexed display and data bus. It keeps its own copy of the five BCD digits and walks through them one at a time. For each digit it raises a single digit-select line and places that digit's BCD value on a shared 4-bit bus. It also drives an active-low strobe, which lets a downstream latch, serial transmitter or processor capture each digit in the middle of its window.

A pulse on the end-of-conversion input does three things. It captures the new digits and the over-range flag. It restarts the scan at the most significant digit, and that first window is one cycle longer than the others. It then makes exactly one strobed pass from the most significant digit down to the least significant digit, with one strobe per digit. After that pass the scan keeps running without strobes. If the captured reading was over range, all digit lines and the bus go dark instead. They stay dark until a deintegrate-start pulse arrives, and then a fresh unstrobed scan begins.

In the requirements below, L is `DIGIT_LEN` (default 200) and S is `STROBE_OFS` (default 100). Cycle n is the n-th rising clock edge after the edge that sampled `eoc_i` high, with n = 0 being the first.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `dsel_o` is 10000 (D5, the most significant digit, selected), `bcd_o` is 0000 and `strobe_n_o` is high. From reset the block scans the all-zero digits without strobes.
- R2: `dsel_o` bit 4 is D5 and bit 0 is D1. At most one bit is high at any time. In an unstrobed scan each digit stays selected for exactly L cycles, in the repeating order D5, D4, D3, D2, D1.
- R3: Whenever a digit is selected, `bcd_o` equals that digit's captured value. Digit Dj (j = 1..5) is taken from `digits_i[4j-1:4j-4]`, so D1 is `digits_i[3:0]` and D5 is `digits_i[19:16]`.
- R4: When `eoc_i` is sampled high, `digits_i` and `ovr_i` are captured. In the next cycle D5 is selected for a window of L+1 cycles (cycles 0..L).
- R5: During the strobed pass, digit k (k = 0 for D5 up to k = 4 for D1) is selected in cycles 1+kL .. L+kL, except that D5 starts at cycle 0. `strobe_n_o` is low only during the low clock phase of cycle 1+kL+S. It stays high during every high clock phase.
- R6: If the captured over-range flag is clear, an unstrobed scan starting at D5 begins in cycle 5L+1 and runs with `strobe_n_o` held high.
- R7: If the captured over-range flag is set, `dsel_o` and `bcd_o` are all zero from cycle 5L+1 onward. When `deint_i` is sampled high in that state, the next cycle starts an unstrobed scan at D5 with full L-cycle windows.
- R8: `deint_i` has no effect outside the blanked state.
- R9: Changes on `digits_i` and `ovr_i` without an end-of-conversion pulse do not change the outputs.
- R10: An end-of-conversion pulse that arrives during a strobed pass abandons that pass and starts a new one, as described in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its low phase also shapes the strobe |
| rst | input | 1 | Synchronous active-high reset |
| eoc_i | input | 1 | End-of-conversion pulse, one cycle wide |
| ovr_i | input | 1 | Over-range flag, captured with `eoc_i` |
| deint_i | input | 1 | Deintegrate-start pulse; ends over-range blanking |
| digits_i | input | 20 | Five BCD digits; D1 is in the lowest nibble |
| dsel_o | output | 5 | One-hot digit select; bit 4 is D5 |
| bcd_o | output | 4 | BCD value of the selected digit |
| strobe_n_o | output | 1 | Active-low strobe, half a clock wide |

## Verification
The outputs change one cycle after each control input is sampled. An `eoc_i` edge shows as D5 and its new value in the next cycle, and a `deint_i` edge ends blanking in the next cycle. The bench drives all inputs on falling edges. It samples one nanosecond after each falling edge, which is inside the low clock phase where a strobe is visible. It also samples half a nanosecond after each rising edge to confirm that the strobe is never low in the high phase. For every sampled cycle the bench computes the expected digit, BCD value and strobe from the cycle count after the sampled pulse, using the formulas in R4 to R7, and compares the complete output vector.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

    localparam int BCD_W = 4;

    // Scanner operating mode
    typedef enum logic [1:0] {
        SCAN_FREE   = 2'd0,   // plain rotating scan, no strobes
        SCAN_STROBE = 2'd1,   // single strobed pass after a conversion
        SCAN_BLANK  = 2'd2    // over-range: all digits dark
    } scan_mode_e;

    // Commands from the mode controller to the window timer
    typedef struct packed {
        logic restart;   // start a stretched first window
        logic resume;    // start a normal window
        logic run;       // advance the window count
    } timer_cmd_t;

    // Status from the window timer
    typedef struct packed {
        logic stretch;   // the extra leading cycle of the first window
        logic win_end;   // last cycle of the current digit window
    } timer_stat_t;

    function automatic int unsigned cnt_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/scan_timer.sv
`timescale 1ns/1ps
module scan_timer
    import scan_pkg::*;
#(
    parameter int DIGIT_LEN = 200,
    localparam int PW = cnt_width(DIGIT_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  timer_cmd_t    cmd_i,
    output logic [PW-1:0] pos_o,
    output timer_stat_t   stat_o
);

    localparam logic [PW-1:0] LAST_POS = PW'(DIGIT_LEN - 1);

    logic [PW-1:0] pos_q;
    logic          stretch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            stretch_q <= 1'b0;
        end else if (cmd_i.restart) begin
            pos_q     <= '0;
            stretch_q <= 1'b1;
        end else if (cmd_i.resume) begin
            pos_q     <= '0;
            stretch_q <= 1'b0;
        end else if (cmd_i.run) begin
            if (stretch_q) begin
                stretch_q <= 1'b0;
            end else if (pos_q == LAST_POS) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + PW'(1);
            end
        end
    end

    assign pos_o          = pos_q;
    assign stat_o.stretch = stretch_q;
    assign stat_o.win_end = cmd_i.run && !stretch_q && (pos_q == LAST_POS);

endmodule

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS = 5,
    localparam int IW = cnt_width(NUM_DIGITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eoc_i,
    input  logic          ovr_i,
    input  logic          deint_i,
    input  timer_stat_t   tstat_i,
    output scan_mode_e    mode_o,
    output logic [IW-1:0] idx_o,
    output timer_cmd_t    cmd_o
);

    localparam logic [IW-1:0] TOP_IDX = IW'(NUM_DIGITS - 1);

    scan_mode_e    mode_q;
    logic [IW-1:0] idx_q;
    logic          ovr_q;
    logic          leave_blank;

    assign leave_blank = (mode_q == SCAN_BLANK) && deint_i && !eoc_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SCAN_FREE;
            idx_q  <= TOP_IDX;
            ovr_q  <= 1'b0;
        end else if (eoc_i) begin
            mode_q <= SCAN_STROBE;
            idx_q  <= TOP_IDX;
            ovr_q  <= ovr_i;
        end else if (leave_blank) begin
            mode_q <= SCAN_FREE;
            idx_q  <= TOP_IDX;
        end else if (tstat_i.win_end) begin
            if (idx_q == '0) begin
                idx_q <= TOP_IDX;
                if (mode_q == SCAN_STROBE) begin
                    mode_q <= ovr_q ? SCAN_BLANK : SCAN_FREE;
                end
            end else begin
                idx_q <= idx_q - IW'(1);
            end
        end
    end

    assign cmd_o.restart = eoc_i;
    assign cmd_o.resume  = leave_blank;
    assign cmd_o.run     = (mode_q != SCAN_BLANK);
    assign mode_o        = mode_q;
    assign idx_o         = idx_q;

endmodule

// File: rtl/digit_store.sv
`timescale 1ns/1ps
module digit_store
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS = 5,
    localparam int IW = cnt_width(NUM_DIGITS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cap_i,
    input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
    input  logic [IW-1:0]               idx_i,
    output logic [BCD_W-1:0]            bcd_o
);

    logic [BCD_W-1:0] held_q [NUM_DIGITS];

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_nib
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q[g] <= '0;
            end else if (cap_i) begin
                held_q[g] <= digits_i[g*BCD_W +: BCD_W];
            end
        end
    end

    always_comb begin
        bcd_o = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (idx_i == IW'(i)) begin
                bcd_o = held_q[i];
            end
        end
    end

endmodule

// File: rtl/bcd_digit_scanner.sv
`timescale 1ns/1ps
module bcd_digit_scanner
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_LEN  = 200,
    parameter int STROBE_OFS = 100
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        eoc_i,
    input  logic                        ovr_i,
    input  logic                        deint_i,
    input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
    output logic [NUM_DIGITS-1:0]       dsel_o,
    output logic [BCD_W-1:0]            bcd_o,
    output logic                        strobe_n_o
);

    localparam int IW = cnt_width(NUM_DIGITS);
    localparam int PW = cnt_width(DIGIT_LEN);
    localparam logic [PW-1:0] STB_POS = PW'(STROBE_OFS);

    scan_mode_e       mode;
    logic [IW-1:0]    idx;
    logic [PW-1:0]    pos;
    timer_cmd_t       tcmd;
    timer_stat_t      tstat;
    logic [BCD_W-1:0] held_bcd;
    logic             lit;
    logic             strobe_win;

    scan_ctrl #(.NUM_DIGITS(NUM_DIGITS)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .eoc_i   (eoc_i),
        .ovr_i   (ovr_i),
        .deint_i (deint_i),
        .tstat_i (tstat),
        .mode_o  (mode),
        .idx_o   (idx),
        .cmd_o   (tcmd)
    );

    scan_timer #(.DIGIT_LEN(DIGIT_LEN)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (tcmd),
        .pos_o  (pos),
        .stat_o (tstat)
    );

    digit_store #(.NUM_DIGITS(NUM_DIGITS)) store_i (
        .clk      (clk),
        .rst      (rst),
        .cap_i    (eoc_i),
        .digits_i (digits_i),
        .idx_i    (idx),
        .bcd_o    (held_bcd)
    );

    assign lit = (mode != SCAN_BLANK);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
        assign dsel_o[g] = lit && (idx == IW'(g));
    end

    assign bcd_o = lit ? held_bcd : '0;

    // Strobe window: one cycle in the middle of each digit of the strobed pass
    assign strobe_win = (mode == SCAN_STROBE) && !tstat.stretch && (pos == STB_POS);

    // Narrowed to the low half of that cycle
    assign strobe_n_o = ~(strobe_win & ~clk);

endmodule

// File: rtl/scan_checker.sv
`timescale 1ns/1ps
module scan_checker #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         eoc_i,
    input logic [N-1:0] dsel,
    input logic [3:0]   bcd,
    input logic         strobe_n
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dsel)) else $error("digit select not one-hot"); // R2

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dsel == '0) |-> (bcd == 4'd0)) else $error("bus not cleared while dark"); // R7

    AST_EOC_MSD: assert property (@(posedge clk) disable iff (rst)
        eoc_i |=> dsel[N-1]) else $error("conversion did not restart at top digit"); // R4

    AST_STROBE_LIT: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> (dsel != '0)) else $error("strobe with no digit selected"); // R5

    AST_BCD_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(eoc_i) && $stable(dsel)) |-> $stable(bcd)) else $error("bus moved without new digit"); // R9

endmodule

bind bcd_digit_scanner scan_checker #(.N(NUM_DIGITS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .eoc_i    (eoc_i),
    .dsel     (dsel_o),
    .bcd      (bcd_o),
    .strobe_n (strobe_n_o)
);

// File: tb/bcd_digit_scanner_tb_top.sv
`timescale 1ns/1ps
module bcd_digit_scanner_tb_top;

    localparam int L  = 6;
    localparam int S  = 3;
    localparam int ND = 5;
    localparam int PASS_END = 5 * L;   // last cycle of the strobed pass

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eoc = 1'b0;
    logic        ovr = 1'b0;
    logic        deint = 1'b0;
    logic [19:0] digits = '0;
    logic [4:0]  dsel;
    logic [3:0]  bcd;
    logic        stb_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_digit_scanner #(.NUM_DIGITS(ND), .DIGIT_LEN(L), .STROBE_OFS(S)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .eoc_i      (eoc),
        .ovr_i      (ovr),
        .deint_i    (deint),
        .digits_i   (digits),
        .dsel_o     (dsel),
        .bcd_o      (bcd),
        .strobe_n_o (stb_n)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] nib(input logic [19:0] d, input int k);
        return d[4*(4-k) +: 4];   // k=0 is D5, k=4 is D1
    endfunction

    // Unstrobed scan, f cycles after its start
    task automatic check_free(input string req, input int f, input logic [19:0] d);
        int k = (f / L) % 5;
        chk(req, "dsel", 32'(dsel), 32'(5'b1 << (4 - k)));
        chk(req, "bcd", 32'(bcd), 32'(nib(d, k)));
        chk(req, "strobe_n", 32'(stb_n), 32'd1);
    endtask

    task automatic check_cycle(input int c, input logic [19:0] d, input logic ov, input string free_req);
        if (c <= PASS_END) begin
            int k = (c == 0) ? 0 : (c - 1) / L;
            chk("R4", "dsel", 32'(dsel), 32'(5'b1 << (4 - k)));
            chk("R3", "bcd", 32'(bcd), 32'(nib(d, k)));
            chk("R5", "strobe_n", 32'(stb_n), (c == 1 + k * L + S) ? 32'd0 : 32'd1);
        end else if (ov) begin
            chk("R7", "dsel", 32'(dsel), 32'd0);
            chk("R7", "bcd", 32'(bcd), 32'd0);
            chk("R7", "strobe_n", 32'(stb_n), 32'd1);
        end else begin
            check_free(free_req, c - PASS_END - 1, d);
        end
    endtask

    // Issue a conversion, then check 'total' cycles. Optionally disturb the digits
    // or pulse deint at a given cycle.
    task automatic do_conv(input logic [19:0] d, input logic ov, input int total,
                           input int mutate_at, input int deint_at, input string free_req);
        @(negedge clk);
        digits = d; ovr = ov; eoc = 1'b1;
        @(negedge clk);
        eoc = 1'b0; ovr = ~ov;
        for (int c = 0; c < total; c++) begin
            if (c == mutate_at) digits = ~d;
            deint = (c == deint_at);
            #1;
            check_cycle(c, d, ov, (c == mutate_at) ? "R9" : free_req);
            @(posedge clk);
            #0.5;
            chk("R5", "strobe_n high phase", 32'(stb_n), 32'd1);
            @(negedge clk);
        end
        deint = 1'b0;
        ovr = 1'b0;
    endtask

    task automatic resume_and_check(input logic [19:0] d, input int total);
        deint = 1'b1;
        @(negedge clk);
        deint = 1'b0;
        for (int f = 0; f < total; f++) begin
            #1;
            check_free("R7", f, d);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, sampled while reset is high
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "dsel in reset", 32'(dsel), 32'h10);
        chk("R1", "bcd in reset", 32'(bcd), 32'h0);
        chk("R1", "strobe_n in reset", 32'(stb_n), 32'h1);
        @(negedge clk);
        rst = 1'b0;
        for (int f = 0; f < 2 * 5 * L; f++) begin
            #1;
            check_free((f < 5 * L) ? "R1" : "R2", f, 20'h0);
            @(negedge clk);
        end

        // R4 R5 R6 R9: normal conversion, digits disturbed after capture
        do_conv(20'h98765, 1'b0, PASS_END + 1 + 2 * 5 * L, 10, -1, "R6");

        // R8: deint pulse during the free scan is ignored
        do_conv(20'h13579, 1'b0, PASS_END + 1 + 5 * L, -1, PASS_END + 4, "R8");

        // R10: a new conversion cuts the strobed pass short
        do_conv(20'h24680, 1'b0, 2 * L + 2, -1, -1, "R10");
        do_conv(20'h50505, 1'b0, PASS_END + 1 + 5 * L, -1, -1, "R10");

        // R7: over-range blanking, deint during the pass ignored, then resume
        do_conv(20'h19999, 1'b1, PASS_END + 1 + 12, -1, 5, "R7");
        resume_and_check(20'h19999, 2 * 5 * L);

        // R3: sweep of every digit value at every position
        for (int v = 0; v < 10; v++) begin
            logic [19:0] d;
            for (int p = 0; p < 5; p++) d[4*p +: 4] = 4'((v + p) % 10);
            do_conv(d, 1'b0, PASS_END + 1 + 5 * L, -1, -1, "R3");
        end

        // R7: a new conversion ends blanking too
        do_conv(20'h00001, 1'b1, PASS_END + 4, -1, -1, "R7");
        do_conv(20'h43210, 1'b0, PASS_END + 1 + 5 * L, -1, -1, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule